// File: doc/BRIEF.md
# DMA Completion and Attention Status Register

This block is the software-visible completion, attention and fault status point of a DMA-fed output channel. A byte written to its single address is held as a command word. Reading the same address returns a status byte. A done flag is set by one of two sources: the end-of-process pulse that marks a finished transfer, or the peripheral's ready level. Software picks the source through the command word. The block also latches attention requests, which can be masked. It keeps a sticky memory-fault flag, and it reports a latched end-of-process indication and the odd-byte transfer state. It combines done and unmasked attention into one interrupt line.

Command bits are levels, not pulses. A clear stays in force for as long as the written word holds it. Software therefore arms a transfer with two writes. The first write sets clear-done together with the chosen done source. The second write sets the done source alone, which releases the clear. A driver polls until done reads 1, and it treats any memory fault seen during that poll as fatal. Writing 0x9C at initialization clears the channel state and done, and selects done on transfer completion.

Top module: `dma_done_status`

## Requirements
- R1: After reset, every status bit reads 0, `irq` is 0 and attention is disabled.
- R2: While the held command word has bit 3 (clear done) set, done (status bit 3) is 0 from the next clock onward, whatever the events.
- R3: With bit 2 held and bit 3 clear, an `eop_pulse` sampled at a clock edge sets done at that edge. Done then stays 1 until clear done is written.
- R4: With bit 1 held and bit 3 clear, `periph_ready` high at a clock edge sets done at that edge.
- R5: An event from the source that is not selected leaves done unchanged.
- R6: Status bits 2 and 1 read back command bits 2 and 1 of the held word, and status bit 7 always reads 0.
- R7: An `attn_pulse` sets status bit 6 whether or not attention is enabled. While command bit 6 is held, the next clock clears the attention latch and holds it at 0.
- R8: A write with bit 4 set and bit 5 clear enables attention. A write with bit 5 set disables it, and disable wins if both are set. `irq` equals done OR (attention latched AND enabled).
- R9: An `mem_err_pulse` sets status bit 4. Only reset clears it; no command affects it.
- R10: An `eop_pulse` sets status bit 5. While command bit 7 is held, the next clock clears that latch and holds it at 0. Status bit 0 shows command bit 0 unless bit 7 is also held, in which case it reads 0.
- R11: Writing 0x9C clears the end-of-process latch, odd state and done on the following clock. After that the status reads 0x04 plus any attention and memory-fault bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low board reset |
| cmd_we | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 8 | Command byte |
| stat_rdata | output | 8 | Status byte |
| eop_pulse | input | 1 | End-of-process pulse from the DMA engine |
| periph_ready | input | 1 | Peripheral ready level |
| attn_pulse | input | 1 | Attention request pulse |
| mem_err_pulse | input | 1 | Memory error pulse |
| irq | output | 1 | Interrupt request |

## Verification
A done flag stuck at 1 would make a busy poll end at once. A done flag stuck at 0 would hang the poll. Either fault shows on status bit 3 and on `irq` in the first cycle after the qualifying event, or after the clear is released. A wrong attention mask shows on `irq` in the cycle after the enable or disable write. A memory fault that clears itself shows on status bit 4 after the first command write that follows the fault. The bench compares the whole status byte and `irq` against its model every cycle, so each of these faults appears within one clock.

// File: rtl/dma_done_status.sv
module dma_done_status #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_we,
  input  logic [W-1:0] cmd_wdata,
  output logic [W-1:0] stat_rdata,
  input  logic         eop_pulse,
  input  logic         periph_ready,
  input  logic         attn_pulse,
  input  logic         mem_err_pulse,
  output logic         irq
);
  logic [W-1:0] cmd_q;
  logic attn_en_q, attn_q, eop_q, done_q, mem_err_q;

  wire clr_chan = cmd_q[7];
  wire clr_attn = cmd_q[6];
  wire clr_done = cmd_q[3];
  wire src_eop  = cmd_q[2];
  wire src_rdy  = cmd_q[1];
  wire hit      = (src_eop & eop_pulse) | (src_rdy & periph_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      attn_en_q <= 1'b0;
      attn_q    <= 1'b0;
      eop_q     <= 1'b0;
      done_q    <= 1'b0;
      mem_err_q <= 1'b0;
    end else begin
      if (cmd_we) begin
        cmd_q <= cmd_wdata;
        if (cmd_wdata[5])      attn_en_q <= 1'b0;
        else if (cmd_wdata[4]) attn_en_q <= 1'b1;
      end
      if (clr_attn)        attn_q <= 1'b0;
      else if (attn_pulse) attn_q <= 1'b1;
      if (clr_chan)        eop_q <= 1'b0;
      else if (eop_pulse)  eop_q <= 1'b1;
      if (clr_done)        done_q <= 1'b0;
      else if (hit)        done_q <= 1'b1;
      if (mem_err_pulse)   mem_err_q <= 1'b1;
    end
  end

  assign stat_rdata = {1'b0, attn_q, eop_q, mem_err_q, done_q, src_eop, src_rdy,
                       cmd_q[0] & ~clr_chan};
  assign irq = done_q | (attn_q & attn_en_q);
endmodule

// File: rtl/dma_done_status_chk.sv
module dma_done_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cmd_q,
  input logic       done_q,
  input logic       attn_q,
  input logic       mem_err_q,
  input logic       eop_pulse,
  input logic       periph_ready,
  input logic       irq
);
  p_clr_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q[3] |=> !done_q);
  p_done_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past((cmd_q[2] && eop_pulse) || (cmd_q[1] && periph_ready)));
  p_clr_attn_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q[6] |=> !attn_q);
  p_irq_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> irq);
  p_mem_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_err_q |=> mem_err_q);
endmodule

bind dma_done_status dma_done_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_q(cmd_q), .done_q(done_q), .attn_q(attn_q),
  .mem_err_q(mem_err_q), .eop_pulse(eop_pulse), .periph_ready(periph_ready), .irq(irq)
);

// File: tb/sim_dma_done_status.sv
module sim_dma_done_status;
  logic clk = 1'b0, rst_n = 1'b0, cmd_we = 1'b0;
  logic [7:0] cmd_wdata = '0;
  logic eop_pulse = 1'b0, periph_ready = 1'b0, attn_pulse = 1'b0, mem_err_pulse = 1'b0;
  logic [7:0] stat_rdata;
  logic irq;
  int checks = 0, fails = 0;
  bit finished = 0;

  logic [7:0] m_cmd;
  logic m_en, m_attn, m_eop, m_done, m_merr;

  always #5 clk = ~clk;

  dma_done_status u0 (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .stat_rdata(stat_rdata), .eop_pulse(eop_pulse), .periph_ready(periph_ready),
    .attn_pulse(attn_pulse), .mem_err_pulse(mem_err_pulse), .irq(irq)
  );

  function automatic logic [7:0] exp_stat();
    return {1'b0, m_attn, m_eop, m_merr, m_done, m_cmd[2], m_cmd[1], m_cmd[0] & ~m_cmd[7]};
  endfunction

  function automatic logic exp_irq();
    return m_done | (m_attn & m_en);
  endfunction

  task automatic check(input string tag);
    checks++;
    if (stat_rdata !== exp_stat() || irq !== exp_irq()) begin
      fails++;
      $display("FAIL %s: stat=%h irq=%b expected stat=%h irq=%b",
               tag, stat_rdata, irq, exp_stat(), exp_irq());
    end
  endtask

  task automatic model_reset();
    m_cmd = '0; m_en = 0; m_attn = 0; m_eop = 0; m_done = 0; m_merr = 0;
  endtask

  task automatic step(input logic w, input logic [7:0] d, input logic e, input logic r,
                      input logic a, input logic m, input string tag);
    logic [7:0] old;
    cmd_we = w; cmd_wdata = d; eop_pulse = e; periph_ready = r;
    attn_pulse = a; mem_err_pulse = m;
    @(posedge clk);
    old = m_cmd;
    if (w) begin
      m_cmd = d;
      if (d[5]) m_en = 0; else if (d[4]) m_en = 1;
    end
    if (old[6]) m_attn = 0; else if (a) m_attn = 1;
    if (old[7]) m_eop = 0; else if (e) m_eop = 1;
    if (old[3]) m_done = 0; else if ((old[2] & e) | (old[1] & r)) m_done = 1;
    if (m) m_merr = 1;
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 8'h00, 0, periph_ready, 0, 0, tag);
  endtask

  task automatic do_reset();
    rst_n = 0; cmd_we = 0; eop_pulse = 0; periph_ready = 0; attn_pulse = 0; mem_err_pulse = 0;
    model_reset();
    repeat (2) @(negedge clk);
    check("R1");
    rst_n = 1;
    @(negedge clk);
    check("R1");
  endtask

  initial begin
    process::self().srandom(32'd1234);
    model_reset();
    do_reset();
    // R10: latch end-of-process, odd state, then clear channel
    step(1, 8'h01, 0, 0, 0, 0, "R10");
    step(0, 8'h00, 1, 0, 0, 0, "R10");
    step(1, 8'h81, 0, 0, 0, 0, "R10");
    step(0, 8'h00, 1, 0, 0, 0, "R10");
    // R11: initialization word
    step(1, 8'h01, 1, 0, 0, 0, "R11");
    step(1, 8'h9C, 0, 0, 0, 0, "R11");
    idle("R11");
    if (stat_rdata !== 8'h04) begin
      fails++;
      $display("FAIL R11: stat=%h expected 04", stat_rdata);
    end
    checks++;
    // R2: clear held blocks done
    step(1, 8'h0C, 1, 0, 0, 0, "R2");
    repeat (3) step(0, 8'h00, 1, 1, 0, 0, "R2");
    // R3: release, then complete
    step(1, 8'h04, 0, 0, 0, 0, "R3");
    step(0, 8'h00, 0, 1, 0, 0, "R5");
    step(0, 8'h00, 1, 0, 0, 0, "R3");
    repeat (3) idle("R3");
    // R4: ready source
    step(1, 8'h0A, 0, 0, 0, 0, "R4");
    step(1, 8'h02, 0, 0, 0, 0, "R4");
    step(0, 8'h00, 1, 0, 0, 0, "R5");
    step(0, 8'h00, 0, 1, 0, 0, "R4");
    step(0, 8'h00, 0, 0, 0, 0, "R6");
    if (stat_rdata[7] !== 1'b0 || stat_rdata[2:1] !== 2'b01) begin
      fails++;
      $display("FAIL R6: stat=%h expected bit7=0 bits2:1=01", stat_rdata);
    end
    checks++;
    // R7/R8: attention masking
    step(1, 8'h08, 0, 0, 0, 0, "R8");
    step(0, 8'h00, 0, 0, 1, 0, "R7");
    step(1, 8'h10, 0, 0, 0, 0, "R8");
    step(1, 8'h30, 0, 0, 0, 0, "R8");
    step(1, 8'h10, 0, 0, 0, 0, "R8");
    step(1, 8'h40, 0, 0, 1, 0, "R7");
    step(0, 8'h00, 0, 0, 1, 0, "R7");
    step(1, 8'h00, 0, 0, 0, 0, "R7");
    // R9: sticky memory fault
    step(0, 8'h00, 0, 0, 0, 1, "R9");
    step(1, 8'hFF, 0, 0, 0, 0, "R9");
    repeat (2) idle("R9");
    do_reset();
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      step(($urandom % 3) == 0, d, ($urandom % 5) == 0, ($urandom % 4) == 0,
           ($urandom % 6) == 0, ($urandom % 40) == 0, "R5");
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule